// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

A slave can stop part-way through a byte while it still wants to drive an acknowledge. It then holds SDA low, and the bus stays busy. This sequencer frees such a bus without touching SCL directly. It sits in front of the control register of an I2C byte engine. When started, it writes that register through a fixed, timed loop: engine disabled, then enabled with master start and transmit set, then enabled only. Each pass makes the engine produce one SCL pulse plus a start and a stop edge. Nine passes give the slave enough clocks to finish its byte and release SDA.

Before the loop begins, the sequencer may write the engine's status register once. It writes the status value it reads, with the arbitration-lost flag cleared. It does this only when the engine reports transfer-complete, bus-busy or no-acknowledge. The waits are counted in microsecond ticks, which come from a prescaler of the system clock. The delay value is programmable and never drops below two ticks. By default the second wait of each pass is twice the first. A mode input makes the two waits equal.

An external timeout monitor decides when to fire the start strobe. The sequencer reports busy while it runs and gives a one-cycle done pulse at the end.

Top module: `i2c_bus_clear_seq`

## Requirements
- R1: One accepted start produces exactly 9 passes, which is exactly 27 control-register writes (`ctrl_wr_o` high for one cycle each).
- R2: Each pass writes, in three consecutive cycles where noted, the values 0x00 then 0xB0 (bit 7 engine enable, bit 5 master start, bit 4 transmit) on the next cycle, and later 0x80 (bit 7 only). A new pass follows directly after the previous second wait.
- R3: The first wait of a pass lasts D*TICK_DIV clock cycles. The 0xB0 write and the following 0x80 write are D*TICK_DIV+1 cycles apart. D is the delay captured when the start is accepted.
- R4: The delay has a floor: a programmed value of 0 or 1 is used as D = 2.
- R5: With `equal_wait_i` = 0, the second wait lasts 2*D*TICK_DIV cycles. With `equal_wait_i` = 1 it lasts D*TICK_DIV cycles. Each 0x80 write comes second-wait+1 cycles before the next 0x00 write or before the done pulse.
- R6: In the cycle after the start is accepted, if any of status bits 7, 5 or 0 is set, `stat_wr_o` pulses once with `stat_wdata_o` equal to the status with bit 4 cleared. If none of those bits is set, no status write occurs.
- R7: `busy_o` rises in the cycle after the accepted start and stays high for 1 + 9*(3 + (D + W2)*TICK_DIV) cycles, where W2 is the second-wait length in ticks. `done_o` is then high for exactly one cycle, with `busy_o` low.
- R8: A start strobe that arrives while `busy_o` is high is ignored. No extra writes or status write occur, and the run ends as if it had not been sent.
- R9: After reset `busy_o`, `done_o`, `stat_wr_o` and `ctrl_wr_o` are low and `ctrl_o` is 0x00. After a completed run `ctrl_o` holds 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe from the timeout monitor |
| delay_us_i | input | DLY_W | Wait unit in microsecond ticks (floor 2) |
| equal_wait_i | input | 1 | 1: second wait equals first; 0: second wait doubled |
| stat_i | input | 8 | Current byte-engine status register |
| stat_wr_o | output | 1 | Status register write strobe (pre-clear) |
| stat_wdata_o | output | 8 | Status write data |
| ctrl_wr_o | output | 1 | Control register write strobe |
| ctrl_o | output | 8 | Control register value |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a start strobe that lands while a recovery is in progress. It must leave the timing and write count of the run unchanged. The bench fires a second strobe in the middle of a run. It then checks that the run still produces 27 writes, a single status write and the full busy length. Delay values below the floor are driven from the vector table. The bench also checks that the measured wait gaps match a delay of two ticks.

// File: rtl/i2c_bus_clear_seq.sv
module i2c_bus_clear_seq #(
  parameter int TICK_DIV = 100,
  parameter int DLY_W    = 12,
  parameter int ITERS    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DLY_W-1:0] delay_us_i,
  input  logic             equal_wait_i,
  input  logic [7:0]       stat_i,
  output logic             stat_wr_o,
  output logic [7:0]       stat_wdata_o,
  output logic             ctrl_wr_o,
  output logic [7:0]       ctrl_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int PW = $clog2(TICK_DIV + 1);
  localparam int CW = DLY_W + 1;
  localparam int IW = $clog2(ITERS + 1);
  localparam logic [7:0] C_EN = 8'h80, C_STA = 8'h20, C_TX = 8'h10;
  localparam logic [7:0] S_CF = 8'h80, S_BB = 8'h20, S_AL = 8'h10, S_NAK = 8'h01;

  typedef enum logic [2:0] {IDLE, PRE, OFF, ON, W1, MEN, W2} st_t;
  st_t st;

  logic [DLY_W-1:0] dly_q, dly_eff;
  logic             alt_q, done_q, tick;
  logic [CW-1:0]    cnt;
  logic [PW-1:0]    pre;
  logic [IW-1:0]    it;
  logic [7:0]       ctrl_q;

  assign dly_eff = (delay_us_i < DLY_W'(2)) ? DLY_W'(2) : delay_us_i;
  assign tick    = (pre == PW'(TICK_DIV - 1));

  assign busy_o       = (st != IDLE);
  assign done_o       = done_q;
  assign stat_wr_o    = (st == PRE) && |(stat_i & (S_CF | S_BB | S_NAK));
  assign stat_wdata_o = stat_i & ~S_AL;
  assign ctrl_wr_o    = (st == OFF) || (st == ON) || (st == MEN);
  assign ctrl_o       = (st == OFF) ? 8'h00 :
                        (st == ON)  ? (C_EN | C_STA | C_TX) :
                        (st == MEN) ? C_EN : ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      dly_q  <= '0;
      alt_q  <= 1'b0;
      cnt    <= '0;
      pre    <= '0;
      it     <= '0;
      done_q <= 1'b0;
      ctrl_q <= 8'h00;
    end else begin
      done_q <= 1'b0;
      ctrl_q <= ctrl_o;
      if (st == W1 || st == W2) pre <= tick ? '0 : pre + 1'b1;
      case (st)
        IDLE: if (start_i) begin
          st    <= PRE;
          dly_q <= dly_eff;
          alt_q <= equal_wait_i;
          it    <= '0;
        end
        PRE: st <= OFF;
        OFF: st <= ON;
        ON: begin
          st  <= W1;
          cnt <= CW'(dly_q);
          pre <= '0;
        end
        W1: if (tick) begin
          if (cnt == CW'(1)) st <= MEN;
          else cnt <= cnt - 1'b1;
        end
        MEN: begin
          st  <= W2;
          cnt <= alt_q ? CW'(dly_q) : (CW'(dly_q) << 1);
          pre <= '0;
        end
        W2: if (tick) begin
          if (cnt == CW'(1)) begin
            if (it == IW'(ITERS - 1)) begin
              st     <= IDLE;
              done_q <= 1'b1;
            end else begin
              st <= OFF;
              it <= it + 1'b1;
            end
          end else cnt <= cnt - 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && ctrl_o == 8'h80));

  // R2
  off_then_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_o && ctrl_o == 8'h00) |=> (ctrl_wr_o && ctrl_o == 8'hB0));

  // R6
  preclr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_o |-> (!stat_wdata_o[4] && busy_o && $past(!busy_o)));

  // R2
  write_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_o |-> (ctrl_o == 8'h00 || ctrl_o == 8'hB0 || ctrl_o == 8'h80));
endmodule

// File: tb/i2c_bus_clear_seq_test.sv
module i2c_bus_clear_seq_test;
  localparam int T  = 5;
  localparam int DW = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, eqw = 1'b0;
  logic [DW-1:0] dly = '0;
  logic [7:0] stat = 8'h00;
  logic stat_wr, ctrl_wr, busy, done;
  logic [7:0] stat_wd, ctrl;

  i2c_bus_clear_seq #(.TICK_DIV(T), .DLY_W(DW), .ITERS(9)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .delay_us_i(dly),
    .equal_wait_i(eqw), .stat_i(stat), .stat_wr_o(stat_wr),
    .stat_wdata_o(stat_wd), .ctrl_wr_o(ctrl_wr), .ctrl_o(ctrl),
    .busy_o(busy), .done_o(done));

  always #5 clk = ~clk;

  int errs = 0, checks = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nw, ns, nd, nb, s_t, d_t;
  int wt [64];
  logic [7:0] wv [64];
  logic [7:0] sv;

  always @(negedge clk) begin
    if (ctrl_wr) begin
      if (nw < 64) begin wt[nw] = cyc; wv[nw] = ctrl; end
      nw++;
    end
    if (stat_wr) begin s_t = cyc; sv = stat_wd; ns++; end
    if (done) begin d_t = cyc; nd++; end
    if (busy) nb++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // vector: {delay[7:0], equal_wait, status[7:0]}
  localparam logic [16:0] VEC [6] = '{
    {8'd3, 1'b0, 8'h00}, {8'd1, 1'b0, 8'hA0}, {8'd0, 1'b1, 8'h81},
    {8'd4, 1'b1, 8'h10}, {8'd2, 1'b0, 8'hFF}, {8'd5, 1'b1, 8'h20}};

  task automatic run(input int d, input bit m, input logic [7:0] st, input bit poke);
    int de, w2, s0, gap_ok1, gap_ok2, pat_ok, lim;
    bit need;
    nw = 0; ns = 0; nd = 0; nb = 0;
    dly = DW'(d); eqw = m; stat = st;
    @(negedge clk); start = 1'b1; s0 = cyc;
    @(negedge clk); start = 1'b0;
    dly = DW'(9); eqw = ~m;
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    lim = 0;
    while (nd == 0 && lim < 20000) begin @(negedge clk); lim++; end
    repeat (3) @(negedge clk);
    de = (d < 2) ? 2 : d;
    w2 = m ? de : 2 * de;
    need = (st[7] | st[5] | st[0]);
    chk(nw == 27, "R1 write count", nw, 27);
    pat_ok = 1; gap_ok1 = 1; gap_ok2 = 1;
    for (int i = 0; i < 9 && nw >= 27; i++) begin
      if (wv[3*i] != 8'h00 || wv[3*i+1] != 8'hB0 || wv[3*i+2] != 8'h80) pat_ok = 0;
      if (wt[3*i+1] != wt[3*i] + 1) pat_ok = 0;
      if (wt[3*i+2] - wt[3*i+1] != de*T + 1) gap_ok1 = 0;
      if (i < 8 && wt[3*i+3] - wt[3*i+2] != w2*T + 1) gap_ok2 = 0;
      if (i == 8 && d_t - wt[3*i+2] != w2*T + 1) gap_ok2 = 0;
    end
    chk(pat_ok == 1, "R2 pass pattern", pat_ok, 1);
    chk(gap_ok1 == 1, (d < 2) ? "R4 floored first wait" : "R3 first wait", gap_ok1, 1);
    chk(gap_ok2 == 1, "R5 second wait", gap_ok2, 1);
    chk(ns == (need ? 1 : 0), "R6 status write count", ns, need);
    if (need) begin
      chk(sv == (st & 8'hEF), "R6 status data", sv, st & 8'hEF);
      chk(s_t == s0 + 1, "R6 status write cycle", s_t, s0 + 1);
    end
    chk(nb == 1 + 9*(3 + (de + w2)*T), poke ? "R8 busy length" : "R7 busy length",
        nb, 1 + 9*(3 + (de + w2)*T));
    chk(nd == 1, "R7 done pulse", nd, 1);
    chk(ctrl == 8'h80, "R9 final control", ctrl, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !ctrl_wr && !stat_wr, "R9 reset outputs", busy, 0);
    chk(ctrl == 8'h00, "R9 reset control", ctrl, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int v = 0; v < 6; v++)
      run(int'(VEC[v][16:9]), VEC[v][8], VEC[v][7:0], 1'b0);
    // R8: start while busy ignored
    run(3, 1'b0, 8'h01, 1'b1);
    // R4: delay of one at floor with equal waits
    run(1, 1'b1, 8'h00, 1'b0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1500000;
    errs++; checks++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule